// File: doc/BRIEF.md
# Interrupt Request Status Flag Bank

This block keeps one pending-request flag for each interrupt source of a chip. Each source input first passes through a two-flop synchronizer. Each source then works in one of two detection modes. In edge mode a rising edge latches the flag. In level mode the flag tracks the synchronized level. A per-source enable gates the flag onto one of three pending vectors: processor, descriptor-transfer engine or bulk-transfer engine. A two-bit selector for each source picks the vector.

Software sees one byte-wide register per source at the address equal to the source number. Only bit 0 holds state. Clearing follows the detection mode and the destination. An edge flag routed to the processor may be cleared by writing 0. A flag routed to either transfer engine cannot be cleared by software. Level flags ignore all writes. Hardware also clears a flag in two cases. The processor acknowledging exception entry for that source clears it. The descriptor engine being activated for that source clears it too, unless the source's keep bit asks that the flag stay set. The downstream priority resolver, vector fetch and transfer engines are outside the block.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag is 0, every register reads 0x00 and no pending output is asserted.
- R2: Reading address i gives 0x00 or 0x01, with bit 0 equal to flag i and bits 7 to 1 always 0.
- R3: In edge mode (mode bit 0), a rising edge on a source input sets its flag, which reads 1 three clock edges after the input changes. A later fall of the input does not clear it.
- R4: In level mode (mode bit 1), the flag equals the synchronized input, with the same three-edge latency, both rising and falling.
- R5: A source's bit is asserted on exactly one pending vector when its flag is 1 and its enable is 1, and on none otherwise. The selector picks the vector: 00 processor, 01 descriptor engine, 10 bulk engine, 11 none.
- R6: In edge mode with selector 00 or 11, a write with data bit 0 = 0 clears the flag on the next edge. A write with bit 0 = 1 leaves the flag unchanged.
- R7: In level mode, writes of any value leave the flag unchanged.
- R8: With selector 01 or 10, software writes of 0 leave an edge-mode flag set.
- R9: A processor acknowledge carrying source number i clears edge flag i when its selector is 00. An acknowledge for another number, or with another selector, has no effect.
- R10: A descriptor-engine acknowledge carrying source number i clears edge flag i when its selector is 01 and its keep bit is 0. With the keep bit at 1 the flag stays set.
- R11: When a new rising edge is detected in the same cycle as any clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw source request inputs |
| level_mode_i | input | NUM_SRC | Detection mode per source, 1 = level |
| enable_i | input | NUM_SRC | Request enable per source |
| sel_i | input | 2*NUM_SRC | Destination selector, 2 bits per source |
| dtc_keep_i | input | NUM_SRC | 1 = descriptor activation does not clear the flag |
| addr_i | input | ID_W | Register address (source number) |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| cpu_ack_i | input | 1 | Processor exception-entry acknowledge |
| cpu_ack_id_i | input | ID_W | Source number being acknowledged by the processor |
| dtc_ack_i | input | 1 | Descriptor engine activation strobe |
| dtc_ack_id_i | input | ID_W | Source number activating the descriptor engine |
| cpu_req_o | output | NUM_SRC | Pending vector toward the processor |
| dtc_req_o | output | NUM_SRC | Pending vector toward the descriptor engine |
| dmac_req_o | output | NUM_SRC | Pending vector toward the bulk engine |

## Verification
The bench goes after the clear paths, which are the easiest to get wrong. A write of 0 to a flag routed to a transfer engine must leave it set, or a request would be silently dropped before the engine sees it. A write of 1 must not arm an edge flag. The bench sends a processor acknowledge with the wrong source number and one with the wrong selector. It also sends a descriptor activation with the keep bit set. A decoder that ignored the number, selector or keep bit would clear the wrong flag. Finally it lines up a fresh edge with an acknowledge in the same cycle. A design that let the clear win would lose that second request.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    DST_CPU  = 2'b00,
    DST_DTC  = 2'b01,
    DST_DMAC = 2'b10,
    DST_NONE = 2'b11
  } dest_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
  import irq_flag_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  logic  level_i,
  input  logic  en_i,
  input  dest_e sel_i,
  input  logic  keep_i,
  input  logic  wr_hit_i,
  input  logic  wr_bit_i,
  input  logic  cpu_ack_hit_i,
  input  logic  dtc_ack_hit_i,
  output logic  flag_o,
  output logic  cpu_req_o,
  output logic  dtc_req_o,
  output logic  dmac_req_o
);
  logic prev_q, flag_q, flag_d;
  logic edge_s, sw_clr, hw_clr, active;

  assign edge_s = sync_i & ~prev_q;

  // software may clear only edge flags owned by the processor side
  assign sw_clr = wr_hit_i & ~wr_bit_i &
                  ((sel_i == DST_CPU) || (sel_i == DST_NONE));
  assign hw_clr = (cpu_ack_hit_i & (sel_i == DST_CPU)) |
                  (dtc_ack_hit_i & (sel_i == DST_DTC) & ~keep_i);

  always_comb begin
    if (level_i) flag_d = sync_i;
    else         flag_d = edge_s | (flag_q & ~(sw_clr | hw_clr));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      flag_q <= flag_d;
    end
  end

  assign active     = flag_q & en_i;
  assign flag_o     = flag_q;
  assign cpu_req_o  = active & (sel_i == DST_CPU);
  assign dtc_req_o  = active & (sel_i == DST_DTC);
  assign dmac_req_o = active & (sel_i == DST_DMAC);

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && sync_i && !prev_q) |=> flag_q);

  // R4
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i |=> (flag_q == $past(sync_i)));

  // R6
  edge_wr1_noset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && wr_hit_i && wr_bit_i && !flag_q && !(sync_i && !prev_q)) |=> !flag_q);

  // R8
  dmac_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && sel_i == DST_DMAC && flag_q) |=> flag_q);

  // R9
  cpu_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && sel_i == DST_CPU && cpu_ack_hit_i && !(sync_i && !prev_q)) |=> !flag_q);

  // R5
  route_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_req_o, dtc_req_o, dmac_req_o}));

  // R5
  route_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_o || dtc_req_o || dmac_req_o) |-> (flag_q && en_i));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [NUM_SRC-1:0]   level_mode_i,
  input  logic [NUM_SRC-1:0]   enable_i,
  input  logic [2*NUM_SRC-1:0] sel_i,
  input  logic [NUM_SRC-1:0]   dtc_keep_i,
  input  logic [ID_W-1:0]      addr_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 cpu_ack_i,
  input  logic [ID_W-1:0]      cpu_ack_id_i,
  input  logic                 dtc_ack_i,
  input  logic [ID_W-1:0]      dtc_ack_id_i,
  output logic [NUM_SRC-1:0]   cpu_req_o,
  output logic [NUM_SRC-1:0]   dtc_req_o,
  output logic [NUM_SRC-1:0]   dmac_req_o
);
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] flags;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_sync)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic wr_hit, cpu_hit, dtc_hit;
    assign wr_hit  = wr_en_i   && (int'(addr_i)       == g);
    assign cpu_hit = cpu_ack_i && (int'(cpu_ack_id_i) == g);
    assign dtc_hit = dtc_ack_i && (int'(dtc_ack_id_i) == g);

    irq_flag_cell u_cell (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .sync_i        (src_sync[g]),
      .level_i       (level_mode_i[g]),
      .en_i          (enable_i[g]),
      .sel_i         (dest_e'(sel_i[2*g +: 2])),
      .keep_i        (dtc_keep_i[g]),
      .wr_hit_i      (wr_hit),
      .wr_bit_i      (wdata_i[0]),
      .cpu_ack_hit_i (cpu_hit),
      .dtc_ack_hit_i (dtc_hit),
      .flag_o        (flags[g]),
      .cpu_req_o     (cpu_req_o[g]),
      .dtc_req_o     (dtc_req_o[g]),
      .dmac_req_o    (dmac_req_o[g])
    );
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (int'(addr_i) == k) rdata_o[0] = flags[k];
    end
  end

  // R2
  rdata_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rdata_o[7:1] == 7'd0));
endmodule

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 16;
  localparam int ID_W       = 4;
  // {sel[1:0], enable, exp_cpu, exp_dtc, exp_dmac}  (R5)
  localparam logic [5:0] ROUTE_TBL [8] = '{
    6'b00_1_100, 6'b01_1_010, 6'b10_1_001, 6'b11_1_000,
    6'b00_0_000, 6'b01_0_000, 6'b10_0_000, 6'b11_0_000
  };

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [NUM_SRC-1:0]   src = '0, lvl = '0, en = '0, keep = '0;
  logic [2*NUM_SRC-1:0] sel = '0;
  logic [ID_W-1:0]      addr = '0, cpu_id = '0, dtc_id = '0;
  logic                 wr_en = 1'b0, cpu_ack = 1'b0, dtc_ack = 1'b0;
  logic [7:0]           wdata = '0, rdata;
  logic [NUM_SRC-1:0]   cpu_req, dtc_req, dmac_req;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .level_mode_i(lvl),
    .enable_i(en), .sel_i(sel), .dtc_keep_i(keep), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .cpu_ack_i(cpu_ack), .cpu_ack_id_i(cpu_id), .dtc_ack_i(dtc_ack),
    .dtc_ack_id_i(dtc_id), .cpu_req_o(cpu_req), .dtc_req_o(dtc_req),
    .dmac_req_o(dmac_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, input string req, input logic [7:0] exp);
    addr = ID_W'(idx); #1;
    check(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    addr = ID_W'(idx); wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx);
    src[idx] = 1'b1; repeat (3) tick();
    src[idx] = 1'b0; repeat (3) tick();
  endtask

  task automatic set_sel(input int idx, input logic [1:0] v);
    sel[2*idx +: 2] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    en = '1;
    repeat (3) tick();
    // R1 reset state
    rd(0, "R1", 8'h00);
    check("R1", {cpu_req, dtc_req}, 32'd0);
    check("R1", {16'd0, dmac_req}, 32'd0);
    rst_ni = 1'b1;
    tick();

    // R3 edge set, latency and hold after fall
    src[2] = 1'b1;
    tick(); tick();
    rd(2, "R3", 8'h00);
    tick();
    rd(2, "R3", 8'h01);
    src[2] = 1'b0; repeat (3) tick();
    rd(2, "R3", 8'h01);
    // R2 upper bits read zero, neighbour unaffected
    rd(3, "R2", 8'h00);

    // R6 write 1 no effect, write 0 clears
    wr(2, 8'hFF);
    rd(2, "R6", 8'h01);
    wr(2, 8'hFE);
    rd(2, "R6", 8'h00);

    // R5 routing table on source 3
    pulse(3);
    for (int k = 0; k < 8; k++) begin
      set_sel(3, ROUTE_TBL[k][5:4]);
      en[3] = ROUTE_TBL[k][3];
      #1;
      check("R5", {29'd0, cpu_req[3], dtc_req[3], dmac_req[3]},
            {29'd0, ROUTE_TBL[k][2:0]});
    end
    en[3] = 1'b1;
    // R6 selector 11 still allows software clear
    wr(3, 8'h00);
    rd(3, "R6", 8'h00);

    // R4 / R7 level mode
    lvl[5] = 1'b1;
    src[5] = 1'b1; repeat (3) tick();
    rd(5, "R4", 8'h01);
    wr(5, 8'h00);
    rd(5, "R7", 8'h01);
    src[5] = 1'b0; tick(); tick();
    rd(5, "R4", 8'h01);
    tick();
    rd(5, "R4", 8'h00);
    wr(5, 8'h01);
    rd(5, "R7", 8'h00);

    // R8 transfer-engine destinations block software clear
    set_sel(6, 2'b01); keep[6] = 1'b1;
    pulse(6);
    wr(6, 8'h00);
    rd(6, "R8", 8'h01);
    set_sel(6, 2'b10);
    wr(6, 8'h00);
    rd(6, "R8", 8'h01);
    check("R8", {31'd0, dmac_req[6]}, 32'd1);

    // R10 descriptor activation with keep, then without
    set_sel(6, 2'b01);
    dtc_id = 4'd6; dtc_ack = 1'b1; tick(); dtc_ack = 1'b0;
    rd(6, "R10", 8'h01);
    keep[6] = 1'b0;
    dtc_ack = 1'b1; tick(); dtc_ack = 1'b0;
    rd(6, "R10", 8'h00);

    // R9 processor acknowledge: wrong selector, wrong id, then match
    set_sel(7, 2'b01);
    pulse(7);
    cpu_id = 4'd7; cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd(7, "R9", 8'h01);
    set_sel(7, 2'b00);
    cpu_id = 4'd8; cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd(7, "R9", 8'h01);
    cpu_id = 4'd7; cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd(7, "R9", 8'h00);

    // R11 new edge coincides with acknowledge
    pulse(8);
    rd(8, "R11", 8'h01);
    src[8] = 1'b1; tick(); tick();
    cpu_id = 4'd8; cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd(8, "R11", 8'h01);
    src[8] = 1'b0; repeat (3) tick();
    cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
    rd(8, "R9", 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule